// File: doc/BRIEF.md
# SMBus Host Command Sequencer

This block sits between a controller that wants to run one SMBus transaction and a byte-level I2C host engine. It accepts a single request (command kind, 7-bit target address, command code, up to 16 bits of write data, a block length) and breaks it into an ordered list of bus operations: start with address and direction, send byte, receive byte, NACK and stop. Each operation goes out on a valid/ready channel and waits for the engine's acknowledgement before the next one is offered.

Reads that need a command code use a repeated start. Word data travels low byte first. Block transfers go through a 32-entry byte buffer. The controller loads that buffer before a block write and reads it back after a block read. When the stop is acknowledged, a one-cycle done pulse is raised. The received data and the byte count are held on output ports until the next request.

Top module: `smb_cmd_seq`

## Requirements
- R1: `req_ready` is high exactly while the sequencer is idle. A request is taken in a cycle with `req_valid` and `req_ready` both high, and `req_valid` while busy has no effect. Kind codes: 0 quick, 1 send byte, 2 receive byte, 3 write byte, 4 read byte, 5 write word, 6 read word, 7 write block, 8 read block; codes 9 to 15 run as quick.
- R2: Only one operation is offered at a time, and it is held stable until `op_ready`. Op codes: 0 start, 1 send, 2 receive, 3 NACK, 4 stop. A start carries the address in `op_byte[7:1]` and the direction in bit 0 (1 = read). Receive, NACK and stop carry `op_byte` = 0. Every transaction begins with a start.
- R3: Quick issues start with the requested direction bit (`req_dir`), then stop.
- R4: Send byte issues start(write), send of `req_wdata[7:0]`, stop. Receive byte issues start(read), receive, NACK, stop, and returns the byte in `done_rdata[7:0]` with the upper byte zero.
- R5: Write byte issues start(write), send code, send `req_wdata[7:0]`, stop. Read byte issues start(write), send code, start(read) to the same address, receive, NACK, stop.
- R6: Word transfers move the low byte first. A write word sends `req_wdata[7:0]` and then `req_wdata[15:8]`. A read word returns {second byte, first byte} and issues its NACK only after the second byte.
- R7: Block read sends the code, issues a repeated start for read, and receives a count byte. A count above 32 becomes 0. That many data bytes follow, stored at buffer indices 0 upward and readable on `buf_rdata`, then NACK and stop.
- R8: Block write clamps `req_len` to 32. It sends the code, the clamped length and buffer bytes 0 to length-1, then stop. A length of 0 sends no data bytes.
- R9: `done` is high for one cycle, in the cycle after the stop is accepted. `done_len` holds the number of data bytes moved (never above 32; 0 for quick) and `done_rdata` holds the byte or word read. Both stay until the next request.
- R10: Buffer writes from the controller (`buf_we`) take effect only while idle. A write during a transaction leaves the buffer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_kind | input | 4 | Command kind code |
| req_addr | input | 7 | Target address |
| req_dir | input | 1 | Direction bit for quick (1 = read) |
| req_code | input | 8 | Command code byte |
| req_wdata | input | 16 | Byte or word write data |
| req_len | input | 8 | Requested block write length |
| buf_we | input | 1 | Controller write to block buffer |
| buf_widx | input | 5 | Buffer write index |
| buf_wdata | input | 8 | Buffer write byte |
| buf_ridx | input | 5 | Buffer read index |
| buf_rdata | output | 8 | Buffer byte at `buf_ridx` |
| op_valid | output | 1 | Bus operation offered |
| op_ready | input | 1 | Engine accepts/completes the operation |
| op_kind | output | 3 | Operation code |
| op_byte | output | 8 | Address+direction or byte to send |
| op_rdata | input | 8 | Byte received, valid with `op_ready` on receive |
| done | output | 1 | Transaction complete pulse |
| done_rdata | output | 16 | Byte or word read |
| done_len | output | 8 | Data byte count of the transaction |

## Verification
The bench covers block counts at the clamp boundary: 32 is kept, 40 becomes zero on reads, and 40 becomes 32 on writes. A design with an off-by-one or a missing clamp would then move the wrong number of bytes or overrun the buffer. Zero-length block writes and zero-count block reads are also checked. A sequencer that entered its data loop before testing for zero would emit a stray send or receive. Word byte order and the position of the NACK after the second byte are compared operation by operation. A request and a buffer write are both injected mid-transaction. If either leaked in, the logged bus sequence or the block bytes being sent would change.

// File: rtl/smb_seq_pkg.sv
// Shared encodings for the SMBus host sequencer.
// Assumes 7-bit addressing and byte-wide data on the engine channel.
package smb_seq_pkg;

    typedef enum logic [3:0] {
        CMD_QUICK   = 4'd0,
        CMD_SEND    = 4'd1,
        CMD_RECV    = 4'd2,
        CMD_WR_BYTE = 4'd3,
        CMD_RD_BYTE = 4'd4,
        CMD_WR_WORD = 4'd5,
        CMD_RD_WORD = 4'd6,
        CMD_WR_BLK  = 4'd7,
        CMD_RD_BLK  = 4'd8
    } cmd_e;

    typedef enum logic [2:0] {
        OP_START = 3'd0,
        OP_SEND  = 3'd1,
        OP_RECV  = 3'd2,
        OP_NACK  = 3'd3,
        OP_STOP  = 3'd4
    } op_e;

    typedef enum logic [3:0] {
        PH_IDLE, PH_START, PH_CODE, PH_LEN, PH_WDATA,
        PH_RSTART, PH_RCNT, PH_RDATA, PH_NACK, PH_STOP
    } phase_e;

    // Write length: saturate at the buffer size.
    function automatic logic [7:0] clamp_wr_len(input logic [7:0] n, input int unsigned lim);
        return (n > 8'(lim)) ? 8'(lim) : n;
    endfunction

    // Read count: anything larger than the buffer is treated as empty.
    function automatic logic [7:0] clamp_rd_cnt(input logic [7:0] n, input int unsigned lim);
        return (n > 8'(lim)) ? 8'd0 : n;
    endfunction

endpackage

// File: rtl/smb_seq_step.sv
// Micro-sequence decoder: given the current phase and command kind,
// selects the bus operation for this phase and the phase that follows
// once the engine acknowledges it. Purely combinational.
// Assumes the caller supplies the loop-end flags for data phases.
module smb_seq_step
    import smb_seq_pkg::*;
(
    input  phase_e phase,
    input  cmd_e   kind,
    input  logic   data_last,
    input  logic   data_none,
    input  logic   rx_none,
    output phase_e phase_nxt,
    output op_e    op
);

    // Operation and successor for each phase
    always_comb begin
        phase_nxt = PH_IDLE;
        op        = OP_STOP;
        case (phase)
            PH_START: begin
                op = OP_START;
                case (kind)
                    CMD_QUICK: phase_nxt = PH_STOP;
                    CMD_SEND:  phase_nxt = PH_WDATA;
                    CMD_RECV:  phase_nxt = PH_RDATA;
                    default:   phase_nxt = PH_CODE;
                endcase
            end
            PH_CODE: begin
                op = OP_SEND;
                case (kind)
                    CMD_WR_BYTE, CMD_WR_WORD: phase_nxt = PH_WDATA;
                    CMD_WR_BLK:               phase_nxt = PH_LEN;
                    default:                  phase_nxt = PH_RSTART;
                endcase
            end
            PH_LEN: begin
                op        = OP_SEND;
                phase_nxt = data_none ? PH_STOP : PH_WDATA;
            end
            PH_WDATA: begin
                op        = OP_SEND;
                phase_nxt = data_last ? PH_STOP : PH_WDATA;
            end
            PH_RSTART: begin
                op        = OP_START;
                phase_nxt = (kind == CMD_RD_BLK) ? PH_RCNT : PH_RDATA;
            end
            PH_RCNT: begin
                op        = OP_RECV;
                phase_nxt = rx_none ? PH_NACK : PH_RDATA;
            end
            PH_RDATA: begin
                op        = OP_RECV;
                phase_nxt = data_last ? PH_NACK : PH_RDATA;
            end
            PH_NACK: begin
                op        = OP_NACK;
                phase_nxt = PH_STOP;
            end
            PH_STOP: begin
                op        = OP_STOP;
                phase_nxt = PH_IDLE;
            end
            default: begin
                op        = OP_STOP;
                phase_nxt = PH_IDLE;
            end
        endcase
    end

endmodule

// File: rtl/smb_blk_buf.sv
// Block data store: one write port, two asynchronous read ports.
// Assumes the caller arbitrates the single write port. No reset on storage.
module smb_blk_buf #(
    parameter int DEPTH = 32,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [7:0]       wdata,
    input  logic [IDX_W-1:0] ra_idx,
    output logic [7:0]       ra_data,
    input  logic [IDX_W-1:0] rb_idx,
    output logic [7:0]       rb_data
);

    logic [7:0] mem [DEPTH];

    // Store one byte per cycle
    always_ff @(posedge clk) begin
        if (we) mem[widx] <= wdata;
    end

    // Read ports for the sequencer and the controller
    always_comb begin
        ra_data = mem[ra_idx];
        rb_data = mem[rb_idx];
    end

endmodule

// File: rtl/smb_cmd_seq.sv
// SMBus host command sequencer top.
// Takes one command request, walks its micro-sequence of bus operations
// over a valid/ready channel to a byte-level I2C host engine, and reports
// completion with a done pulse, read data and byte count.
// Assumes the engine holds op_ready for one cycle per accepted operation
// and presents received data on op_rdata in that same cycle.
module smb_cmd_seq
    import smb_seq_pkg::*;
#(
    parameter int BLK_MAX = 32,
    parameter int IDX_W   = $clog2(BLK_MAX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [3:0]       req_kind,
    input  logic [6:0]       req_addr,
    input  logic             req_dir,
    input  logic [7:0]       req_code,
    input  logic [15:0]      req_wdata,
    input  logic [7:0]       req_len,
    input  logic             buf_we,
    input  logic [IDX_W-1:0] buf_widx,
    input  logic [7:0]       buf_wdata,
    input  logic [IDX_W-1:0] buf_ridx,
    output logic [7:0]       buf_rdata,
    output logic             op_valid,
    input  logic             op_ready,
    output logic [2:0]       op_kind,
    output logic [7:0]       op_byte,
    input  logic [7:0]       op_rdata,
    output logic             done,
    output logic [15:0]      done_rdata,
    output logic [7:0]       done_len
);

    phase_e      phase_q, phase_nxt;
    cmd_e        kind_q, kind_in;
    op_e         op_cur;
    logic [6:0]  addr_q;
    logic        dir_q;
    logic [7:0]  code_q;
    logic [15:0] wdata_q;
    logic [7:0]  cnt_q, cnt_in;
    logic [7:0]  idx_q;
    logic [15:0] rdata_q;
    logic        done_q;
    logic        req_fire, op_fire;
    logic        data_last, data_none, rx_none;
    logic [7:0]  seq_rbyte;
    logic        mem_we;
    logic [IDX_W-1:0] mem_widx;
    logic [7:0]  mem_wdata;
    logic        seq_blk_wr;
    logic        start_rd;

    assign req_ready = (phase_q == PH_IDLE);
    assign req_fire  = req_valid && req_ready;
    assign op_valid  = (phase_q != PH_IDLE);
    assign op_fire   = op_valid && op_ready;
    assign op_kind   = op_cur;

    assign data_last = ((idx_q + 8'd1) == cnt_q);
    assign data_none = (cnt_q == 8'd0);
    assign rx_none   = (clamp_rd_cnt(op_rdata, BLK_MAX) == 8'd0);

    // Decode incoming kind; unassigned codes run as quick
    always_comb begin
        kind_in = (req_kind > 4'd8) ? CMD_QUICK : cmd_e'(req_kind);
        case (kind_in)
            CMD_SEND, CMD_RECV, CMD_WR_BYTE, CMD_RD_BYTE: cnt_in = 8'd1;
            CMD_WR_WORD, CMD_RD_WORD:                     cnt_in = 8'd2;
            CMD_WR_BLK: cnt_in = clamp_wr_len(req_len, BLK_MAX);
            default:    cnt_in = 8'd0;
        endcase
    end

    smb_seq_step u_step (
        .phase     (phase_q),
        .kind      (kind_q),
        .data_last (data_last),
        .data_none (data_none),
        .rx_none   (rx_none),
        .phase_nxt (phase_nxt),
        .op        (op_cur)
    );

    // Byte placed on the channel for the current phase
    always_comb begin
        start_rd = (kind_q == CMD_QUICK) ? dir_q : (kind_q == CMD_RECV);
        case (phase_q)
            PH_START:  op_byte = {addr_q, start_rd};
            PH_RSTART: op_byte = {addr_q, 1'b1};
            PH_CODE:   op_byte = code_q;
            PH_LEN:    op_byte = cnt_q;
            PH_WDATA: begin
                case (kind_q)
                    CMD_WR_WORD: op_byte = idx_q[0] ? wdata_q[15:8] : wdata_q[7:0];
                    CMD_WR_BLK:  op_byte = seq_rbyte;
                    default:     op_byte = wdata_q[7:0];
                endcase
            end
            default:   op_byte = 8'd0;
        endcase
    end

    // Buffer write arbitration: received block bytes, else controller when idle
    always_comb begin
        seq_blk_wr = op_fire && (phase_q == PH_RDATA) && (kind_q == CMD_RD_BLK);
        mem_we     = seq_blk_wr || (buf_we && req_ready);
        mem_widx   = seq_blk_wr ? idx_q[IDX_W-1:0] : buf_widx;
        mem_wdata  = seq_blk_wr ? op_rdata : buf_wdata;
    end

    smb_blk_buf #(.DEPTH(BLK_MAX), .IDX_W(IDX_W)) u_buf (
        .clk     (clk),
        .we      (mem_we),
        .widx    (mem_widx),
        .wdata   (mem_wdata),
        .ra_idx  (idx_q[IDX_W-1:0]),
        .ra_data (seq_rbyte),
        .rb_idx  (buf_ridx),
        .rb_data (buf_rdata)
    );

    // Sequencer state, request capture and result collection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            kind_q  <= CMD_QUICK;
            addr_q  <= 7'd0;
            dir_q   <= 1'b0;
            code_q  <= 8'd0;
            wdata_q <= 16'd0;
            cnt_q   <= 8'd0;
            idx_q   <= 8'd0;
            rdata_q <= 16'd0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (req_fire) begin
                phase_q <= PH_START;
                kind_q  <= kind_in;
                addr_q  <= req_addr;
                dir_q   <= req_dir;
                code_q  <= req_code;
                wdata_q <= req_wdata;
                cnt_q   <= cnt_in;
                idx_q   <= 8'd0;
                rdata_q <= 16'd0;
            end else if (op_fire) begin
                phase_q <= phase_nxt;
                idx_q   <= (phase_nxt == phase_q) ? idx_q + 8'd1 : 8'd0;
                if (phase_q == PH_RCNT)
                    cnt_q <= clamp_rd_cnt(op_rdata, BLK_MAX);
                if (phase_q == PH_RDATA && kind_q != CMD_RD_BLK) begin
                    if (idx_q[0]) rdata_q[15:8] <= op_rdata;
                    else          rdata_q[7:0]  <= op_rdata;
                end
                if (phase_q == PH_STOP)
                    done_q <= 1'b1;
            end
        end
    end

    assign done       = done_q;
    assign done_rdata = rdata_q;
    assign done_len   = cnt_q;

endmodule

// File: rtl/smb_cmd_seq_chk.sv
// Protocol checker for the SMBus host sequencer, bound to every instance.
// Assumes synchronous active-low reset; all properties are off during reset.
module smb_cmd_seq_chk #(
    parameter int BLK_MAX = 32
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_ready,
    input logic        op_valid,
    input logic        op_ready,
    input logic [2:0]  op_kind,
    input logic [7:0]  op_byte,
    input logic        done,
    input logic [7:0]  done_len
);

    AST_IDLE_NO_OP: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !op_valid); // R1

    AST_OP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !op_ready) |=> (op_valid && $stable(op_kind) && $stable(op_byte))); // R2

    AST_FIRST_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(op_valid) |-> (op_kind == 3'd0)); // R2

    AST_DONE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(op_valid && op_ready && op_kind == 3'd4)); // R9

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_LEN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (done_len <= 8'(BLK_MAX))); // R7

endmodule

bind smb_cmd_seq smb_cmd_seq_chk #(.BLK_MAX(BLK_MAX)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .op_valid  (op_valid),
    .op_ready  (op_ready),
    .op_kind   (op_kind),
    .op_byte   (op_byte),
    .done      (done),
    .done_len  (done_len)
);

// File: tb/tb_smb_cmd_seq.sv
`timescale 1ns/1ps
// Directed bench: a responder models the host engine and logs every
// accepted operation; each scenario task compares the log and results.
module tb_smb_cmd_seq;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_ready, req_dir;
    logic [3:0]  req_kind;
    logic [6:0]  req_addr;
    logic [7:0]  req_code, req_len;
    logic [15:0] req_wdata;
    logic        buf_we;
    logic [4:0]  buf_widx, buf_ridx;
    logic [7:0]  buf_wdata, buf_rdata;
    logic        op_valid, op_ready;
    logic [2:0]  op_kind;
    logic [7:0]  op_byte, op_rdata;
    logic        done;
    logic [15:0] done_rdata;
    logic [7:0]  done_len;

    int n_chk = 0, n_fail = 0;
    logic [10:0] log_q [0:63];
    logic [10:0] exp_q [0:63];
    logic [7:0]  rx_q  [0:63];
    int log_n = 0, exp_n = 0, rx_ptr = 0, stall_cfg = 0;
    bit done_seen = 0;
    logic [15:0] cap_rdata;
    logic [7:0]  cap_len;

    always #2.5 clk = ~clk;

    smb_cmd_seq dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_addr(req_addr), .req_dir(req_dir), .req_code(req_code),
        .req_wdata(req_wdata), .req_len(req_len),
        .buf_we(buf_we), .buf_widx(buf_widx), .buf_wdata(buf_wdata),
        .buf_ridx(buf_ridx), .buf_rdata(buf_rdata),
        .op_valid(op_valid), .op_ready(op_ready), .op_kind(op_kind),
        .op_byte(op_byte), .op_rdata(op_rdata),
        .done(done), .done_rdata(done_rdata), .done_len(done_len)
    );

    // Engine model: acknowledge after stall_cfg cycles, log op, feed receive data
    initial begin
        int stall;
        stall = 0; op_ready = 1'b0; op_rdata = 8'd0;
        forever begin
            @(negedge clk);
            op_ready = 1'b0;
            if (done) begin
                done_seen = 1; cap_rdata = done_rdata; cap_len = done_len;
            end
            if (rst_n && op_valid) begin
                if (stall > 0) stall--;
                else begin
                    if (log_n < 64) log_q[log_n] = {op_kind, op_byte};
                    log_n++;
                    if (op_kind == 3'd2 && rx_ptr < 64) begin
                        op_rdata = rx_q[rx_ptr]; rx_ptr++;
                    end
                    op_ready = 1'b1;
                    stall = stall_cfg;
                end
            end
        end
    end

    task automatic check(input string req, input bit ok, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic ex(input logic [2:0] k, input logic [7:0] b);
        exp_q[exp_n] = {k, b}; exp_n++;
    endtask

    task automatic check_seq(input string req);
        int bad;
        bad = -1;
        check({req, " op count"}, log_n == exp_n, log_n, exp_n);
        for (int i = 0; i < exp_n && i < log_n; i++)
            if (bad < 0 && log_q[i] !== exp_q[i]) bad = i;
        if (bad >= 0) check({req, " op sequence"}, 0, log_q[bad], exp_q[bad]);
        else          check({req, " op sequence"}, 1, 0, 0);
    endtask

    task automatic load_buf(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            buf_we = 1'b1; buf_widx = 5'(i); buf_wdata = 8'(i * 3 + 1);
        end
        @(negedge clk); buf_we = 1'b0;
    endtask

    // Issue one request and wait for done; optionally intrude while busy
    task automatic run_cmd(input logic [3:0] kind, input logic [6:0] addr, input logic dir,
                           input logic [7:0] code, input logic [15:0] wd, input logic [7:0] len,
                           input bit intrude);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        log_n = 0; rx_ptr = 0; done_seen = 0; exp_n = 0;
        req_kind = kind; req_addr = addr; req_dir = dir; req_code = code;
        req_wdata = wd; req_len = len; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (intrude) begin
            repeat (3) @(negedge clk);
            check("R1 ready low while busy", req_ready == 1'b0, req_ready, 0);
            req_valid = 1'b1; req_kind = 4'd0;
            buf_we = 1'b1; buf_widx = 5'd20; buf_wdata = 8'hFF;
            @(negedge clk);
            req_valid = 1'b0; buf_we = 1'b0;
        end
        for (int i = 0; i < 4000 && !done_seen; i++) @(negedge clk);
        check("R9 done seen", done_seen, done_seen, 1);
        repeat (10) @(negedge clk);
    endtask

    task automatic t_quick;
        stall_cfg = 0;
        run_cmd(4'd0, 7'h50, 1'b1, 8'h00, 16'h0, 8'd0, 0);
        ex(0, 8'hA1); ex(4, 0); check_seq("R3 quick read");
        check("R9 quick len", cap_len == 0, cap_len, 0);
        run_cmd(4'd0, 7'h50, 1'b0, 8'h00, 16'h0, 8'd0, 0);
        ex(0, 8'hA0); ex(4, 0); check_seq("R3 quick write");
        run_cmd(4'd12, 7'h11, 1'b1, 8'h33, 16'h0, 8'd0, 0);
        ex(0, 8'h23); ex(4, 0); check_seq("R1 unassigned kind runs as quick");
    endtask

    task automatic t_send_recv;
        stall_cfg = 2;
        run_cmd(4'd1, 7'h12, 1'b0, 8'h00, 16'h005A, 8'd0, 0);
        ex(0, 8'h24); ex(1, 8'h5A); ex(4, 0); check_seq("R4 send byte");
        rx_q[0] = 8'hC3;
        run_cmd(4'd2, 7'h12, 1'b0, 8'h00, 16'h0, 8'd0, 0);
        ex(0, 8'h25); ex(2, 0); ex(3, 0); ex(4, 0); check_seq("R4 receive byte");
        check("R4 receive data", cap_rdata == 16'h00C3, cap_rdata, 16'h00C3);
    endtask

    task automatic t_byte_rw;
        stall_cfg = 1;
        run_cmd(4'd3, 7'h2C, 1'b0, 8'h10, 16'h0077, 8'd0, 0);
        ex(0, 8'h58); ex(1, 8'h10); ex(1, 8'h77); ex(4, 0); check_seq("R5 write byte");
        rx_q[0] = 8'h9E;
        run_cmd(4'd4, 7'h2C, 1'b0, 8'h21, 16'h0, 8'd0, 0);
        ex(0, 8'h58); ex(1, 8'h21); ex(0, 8'h59); ex(2, 0); ex(3, 0); ex(4, 0);
        check_seq("R5 read byte");
        check("R5 read byte data", cap_rdata == 16'h009E, cap_rdata, 16'h009E);
    endtask

    task automatic t_word;
        stall_cfg = 0;
        run_cmd(4'd5, 7'h3A, 1'b0, 8'h44, 16'hBEEF, 8'd0, 0);
        ex(0, 8'h74); ex(1, 8'h44); ex(1, 8'hEF); ex(1, 8'hBE); ex(4, 0);
        check_seq("R6 write word");
        rx_q[0] = 8'h34; rx_q[1] = 8'h12;
        run_cmd(4'd6, 7'h3A, 1'b0, 8'h45, 16'h0, 8'd0, 0);
        ex(0, 8'h74); ex(1, 8'h45); ex(0, 8'h75); ex(2, 0); ex(2, 0); ex(3, 0); ex(4, 0);
        check_seq("R6 read word");
        check("R6 word order", cap_rdata == 16'h1234, cap_rdata, 16'h1234);
        check("R9 word len", cap_len == 2, cap_len, 2);
    endtask

    task automatic t_blk_write;
        stall_cfg = 0;
        load_buf(32);
        run_cmd(4'd7, 7'h08, 1'b0, 8'h60, 16'h0, 8'd40, 0);
        ex(0, 8'h10); ex(1, 8'h60); ex(1, 8'd32);
        for (int i = 0; i < 32; i++) ex(1, 8'(i * 3 + 1));
        ex(4, 0); check_seq("R8 block write clamp 40->32");
        check("R8 block write len", cap_len == 32, cap_len, 32);
        run_cmd(4'd7, 7'h08, 1'b0, 8'h61, 16'h0, 8'd3, 0);
        ex(0, 8'h10); ex(1, 8'h61); ex(1, 8'd3); ex(1, 8'd1); ex(1, 8'd4); ex(1, 8'd7); ex(4, 0);
        check_seq("R8 block write 3");
        run_cmd(4'd7, 7'h08, 1'b0, 8'h62, 16'h0, 8'd0, 0);
        ex(0, 8'h10); ex(1, 8'h62); ex(1, 8'd0); ex(4, 0);
        check_seq("R8 block write empty");
    endtask

    task automatic t_busy_intrude;
        stall_cfg = 1;
        load_buf(32);
        run_cmd(4'd7, 7'h09, 1'b0, 8'h70, 16'h0, 8'd32, 1);
        ex(0, 8'h12); ex(1, 8'h70); ex(1, 8'd32);
        for (int i = 0; i < 32; i++) ex(1, 8'(i * 3 + 1));
        ex(4, 0); check_seq("R10 R1 busy writes and requests ignored");
        buf_ridx = 5'd20; #1;
        check("R10 buffer byte 20 unchanged", buf_rdata == 8'd61, buf_rdata, 61);
    endtask

    task automatic t_blk_read;
        stall_cfg = 0;
        rx_q[0] = 8'd5;
        for (int i = 1; i <= 5; i++) rx_q[i] = 8'(8'hA0 + i);
        run_cmd(4'd8, 7'h40, 1'b0, 8'h80, 16'h0, 8'd0, 0);
        ex(0, 8'h80); ex(1, 8'h80); ex(0, 8'h81); ex(2, 0);
        for (int i = 0; i < 5; i++) ex(2, 0);
        ex(3, 0); ex(4, 0); check_seq("R7 block read 5");
        check("R7 block read len", cap_len == 5, cap_len, 5);
        for (int i = 0; i < 5; i++) begin
            buf_ridx = 5'(i); #1;
            check("R7 block read data", buf_rdata == 8'(8'hA1 + i), buf_rdata, 8'hA1 + i);
        end
        rx_q[0] = 8'd40;
        run_cmd(4'd8, 7'h40, 1'b0, 8'h81, 16'h0, 8'd0, 0);
        ex(0, 8'h80); ex(1, 8'h81); ex(0, 8'h81); ex(2, 0); ex(3, 0); ex(4, 0);
        check_seq("R7 block read count 40 -> 0");
        check("R7 oversized count len", cap_len == 0, cap_len, 0);
        stall_cfg = 1;
        rx_q[0] = 8'd32;
        for (int i = 1; i <= 32; i++) rx_q[i] = 8'(255 - i);
        run_cmd(4'd8, 7'h40, 1'b0, 8'h82, 16'h0, 8'd0, 0);
        ex(0, 8'h80); ex(1, 8'h82); ex(0, 8'h81); ex(2, 0);
        for (int i = 0; i < 32; i++) ex(2, 0);
        ex(3, 0); ex(4, 0); check_seq("R7 block read 32");
        buf_ridx = 5'd31; #1;
        check("R7 last block byte", buf_rdata == 8'd223, buf_rdata, 223);
    endtask

    // Watchdog: a hung run is a failure and still reports
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_kind = 0; req_addr = 0; req_dir = 0;
        req_code = 0; req_wdata = 0; req_len = 0;
        buf_we = 1'b0; buf_widx = 0; buf_wdata = 0; buf_ridx = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset ready", req_ready == 1'b1, req_ready, 1);
        check("R2 reset no op", op_valid == 1'b0, op_valid, 0);
        check("R9 reset no done", done == 1'b0, done, 0);
        t_quick();
        t_send_recv();
        t_byte_rw();
        t_word();
        t_blk_write();
        t_busy_intrude();
        t_blk_read();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule